// File: doc/BRIEF.md
# Multi-Queue FIFO Read Port Controller

This block lets one word store serve many independent first-in first-out queues. Every queue owns a private write pointer and read pointer into its slice of the store. A producer picks the queue it fills by presenting a queue number together with a strobe. A consumer picks the queue it drains the same way on its own address bus. Both sides share one clock. A selection is a registered event, so it takes effect on the edge where the strobe is sampled.

On the read side the block returns 18-bit words in arrival order. It drives an active-low almost-empty indication for the queue now being drained. It also drives an active-low output-valid flag, which passes through a two-register pipeline so that it lines up with the registered data path. The flag therefore describes a newly chosen queue two edges after the selection.

A queue can be emptied on its own by a partial reset. This clears only that queue's two pointers. The block accepts a partial reset only when both ports have had the same queue selected for at least two edges.

Top module: `mq_rdport_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, every queue becomes empty and no queue is selected on either port. After that edge `rd_data` is 0, `out_valid_n` is 1 and `almost_empty_n` is 1.
- R2: `wr_addr` is taken as the write queue at a rising edge where `wr_addr_en` is 1. `rd_addr` is taken as the read queue at an edge where `rd_addr_en` is 1 and `flag_strobe` is 0. At any other edge the address buses have no effect, and a new selection applies from the next edge on.
- R3: At an edge where a write queue is selected and `wr_en_n` is 0, `wr_data` is appended to that queue, unless the queue already holds 16 words. A write to a full queue is dropped.
- R4: At an edge where a read queue is selected, `rd_en_n` is 0, `out_en_n` is 0 and the queue is not empty, the oldest word of that queue is removed. That word appears on `rd_data` after the edge, so each queue returns words in the order they were written.
- R5: A read attempt is ignored when no read queue is selected, when the queue is empty, or when `out_en_n` is 1. In each case `rd_data` keeps its previous value.
- R6: `out_valid_n` is a two-stage registered copy of "no read queue selected, or the selected read queue is empty". It is sampled at each edge, so after edge n+2 it shows the condition as it stood just before edge n+1. It goes to 1 two edges after the selected queue is read to empty.
- R7: `almost_empty_n` is 0 exactly while a read queue is selected and that queue holds 2 words or fewer. It follows the pointer and selection state of the current cycle.
- R8: At an edge where `part_rst_n` is 0, the block checks three things: the same queue is selected on both ports, the write selection was loaded at least two edges earlier, and the read selection was loaded at least two edges earlier. If all hold, that queue becomes empty, no read or write happens at that edge, and all other queues keep their contents. Otherwise `part_rst_n` has no effect.
- R9: A write or a partial reset on one queue leaves the contents and order of every other queue unchanged.
- R10: At an edge where `rd_addr_en` and `flag_strobe` are both 1, the combination is illegal and the read selection stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous active-low master reset |
| wr_addr | input | 5 | Queue number for the write side |
| wr_addr_en | input | 1 | Loads `wr_addr` as the write queue |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | 18 | Word to append |
| rd_addr | input | 5 | Queue number for the read side |
| rd_addr_en | input | 1 | Loads `rd_addr` as the read queue |
| flag_strobe | input | 1 | Flag-bus strobe; blocks a read selection in the same cycle |
| rd_en_n | input | 1 | Active-low read request |
| out_en_n | input | 1 | Active-low output enable; reads happen only while low |
| part_rst_n | input | 1 | Active-low partial reset of the queue selected on both ports |
| rd_data | output | 18 | Last word read |
| out_valid_n | output | 1 | Active-low output-valid flag, two-stage pipelined |
| almost_empty_n | output | 1 | Active-low almost-empty flag of the read queue |

## Verification
The two per-queue pointers are hidden state. If one of them is wrong, the effect shows at the ports only when that queue is drained: words come out of order, come out missing, or come out duplicated. `almost_empty_n` shows the error at once, because it depends on the pointers in the same cycle. `out_valid_n` shows it two edges later.

A wrong selection register or a wrong settle counter shows up in a different way. Data comes from the wrong queue, or a partial reset is taken or refused one edge off. The other queues are left intact, and the bench confirms this when it later drains them.

// File: rtl/mq_pkg.sv
// Package: shared defaults and the pointer action type for the multi-queue store.
// Assumes depth per queue is a power of two.
package mq_pkg;
    localparam int MQ_NUM_Q_DEF    = 32;
    localparam int MQ_DEPTH_DEF    = 16;
    localparam int MQ_WIDTH_DEF    = 18;
    localparam int MQ_AE_LEVEL_DEF = 2;
    localparam int MQ_OV_STAGES    = 2;
    localparam int MQ_PRS_LEAD     = 2;

    typedef enum logic [1:0] {
        PA_HOLD  = 2'd0,
        PA_STEP  = 2'd1,
        PA_CLEAR = 2'd2
    } ptr_act_e;
endpackage

// File: rtl/mq_sel_port.sv
// Module: holds the queue chosen on one port and counts edges since it was loaded.
// Assumes: load is a one-cycle strobe; settled rises LEAD edges after a load.
module mq_sel_port #(
    parameter int QW   = 5,
    parameter int LEAD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [QW-1:0] addr,
    output logic [QW-1:0] sel_q,
    output logic          sel_vld,
    output logic          settled
);
    localparam int AGW = $clog2(LEAD + 1);

    logic [AGW-1:0] age;

    // Purpose: capture the queue number on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            sel_vld <= 1'b0;
        end else if (load) begin
            sel_q   <= addr;
            sel_vld <= 1'b1;
        end
    end

    // Purpose: count edges since the last load, saturating at LEAD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (load) begin
            age <= AGW'(1);
        end else if (sel_vld && (age < AGW'(LEAD))) begin
            age <= age + AGW'(1);
        end
    end

    assign settled = sel_vld && (age >= AGW'(LEAD));

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sel_vld && sel_q == $past(addr)));   // R2
    AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> $stable(sel_q));   // R2
endmodule

// File: rtl/mq_ptr_table.sv
// Module: per-queue write and read pointers with fill counts and per-queue clear.
// Assumes: callers only step a pointer when the queue is not full (write)
// or not empty (read); clear has priority over stepping.
module mq_ptr_table
    import mq_pkg::*;
#(
    parameter int NUM_Q    = 32,
    parameter int DEPTH    = 16,
    parameter int AE_LEVEL = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(NUM_Q)-1:0] wq,
    input  logic [$clog2(NUM_Q)-1:0] rq,
    input  logic                 wr_fire,
    input  logic                 rd_fire,
    input  logic                 clr,
    input  logic [$clog2(NUM_Q)-1:0] clr_q,
    output logic [$clog2(DEPTH)-1:0] w_slot,
    output logic [$clog2(DEPTH)-1:0] r_slot,
    output logic                 w_full,
    output logic [$clog2(DEPTH):0] r_cnt,
    output logic                 r_near_empty
);
    localparam int QW = $clog2(NUM_Q);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr_a [NUM_Q];
    logic [PW-1:0] rptr_a [NUM_Q];
    logic [PW-1:0] cnt_a  [NUM_Q];

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        ptr_act_e w_act, r_act;

        // Purpose: pick what this queue's pointers do at the coming edge.
        always_comb begin
            w_act = PA_HOLD;
            r_act = PA_HOLD;
            if (clr && clr_q == QW'(g)) begin
                w_act = PA_CLEAR;
                r_act = PA_CLEAR;
            end else begin
                if (wr_fire && wq == QW'(g)) w_act = PA_STEP;
                if (rd_fire && rq == QW'(g)) r_act = PA_STEP;
            end
        end

        // Purpose: apply the chosen action to the write pointer.
        always_ff @(posedge clk) begin
            if (!rst_n) wptr_a[g] <= '0;
            else begin
                case (w_act)
                    PA_STEP:  wptr_a[g] <= wptr_a[g] + PW'(1);
                    PA_CLEAR: wptr_a[g] <= '0;
                    default:  wptr_a[g] <= wptr_a[g];
                endcase
            end
        end

        // Purpose: apply the chosen action to the read pointer.
        always_ff @(posedge clk) begin
            if (!rst_n) rptr_a[g] <= '0;
            else begin
                case (r_act)
                    PA_STEP:  rptr_a[g] <= rptr_a[g] + PW'(1);
                    PA_CLEAR: rptr_a[g] <= '0;
                    default:  rptr_a[g] <= rptr_a[g];
                endcase
            end
        end

        assign cnt_a[g] = wptr_a[g] - rptr_a[g];

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_a[g] <= PW'(DEPTH));   // R3
        AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && clr_q == QW'(g)) |=> (cnt_a[g] == '0));   // R8
        AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_fire && wq == QW'(g)) && !(rd_fire && rq == QW'(g)) &&
             !(clr && clr_q == QW'(g))) |=> $stable(cnt_a[g]));   // R9
    end

    assign w_slot       = wptr_a[wq][AW-1:0];
    assign r_slot       = rptr_a[rq][AW-1:0];
    assign w_full       = (cnt_a[wq] == PW'(DEPTH));
    assign r_cnt        = cnt_a[rq];
    assign r_near_empty = (cnt_a[rq] <= PW'(AE_LEVEL));
endmodule

// File: rtl/mq_word_store.sv
// Module: shared word store, one slice of DEPTH words per queue, registered read.
// Assumes: the caller never reads and writes the same slot in one cycle.
module mq_word_store #(
    parameter int NUM_Q = 32,
    parameter int DEPTH = 16,
    parameter int WIDTH = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NUM_Q*DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     re,
    input  logic [$clog2(NUM_Q*DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    localparam int ENTRIES = NUM_Q * DEPTH;

    logic [WIDTH-1:0] mem [ENTRIES];

    // Purpose: store an incoming word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Purpose: register the word being read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/mq_valid_pipe.sv
// Module: delays the "nothing valid" status by STAGES registers to match the data path.
// Assumes: all stages reset to the invalid level (1).
module mq_valid_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic invalid_in,
    output logic valid_n
);
    logic [STAGES-1:0] stg;

    // Purpose: shift the status through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '1;
        else if (STAGES == 1) stg <= invalid_in;
        else stg <= {stg[STAGES-2:0], invalid_in};
    end

    assign valid_n = stg[STAGES-1];

    AST_OV_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (valid_n == $past(invalid_in, 2)));   // R6
endmodule

// File: rtl/mq_rdport_ctrl.sv
// Module: top of the multi-queue controller. Combines the port selections,
// the pointer table, the word store and the output-valid pipeline.
// Assumes: one common clock, synchronous active-low master reset, DEPTH a power of two.
module mq_rdport_ctrl
    import mq_pkg::*;
#(
    parameter int NUM_Q     = MQ_NUM_Q_DEF,
    parameter int DEPTH     = MQ_DEPTH_DEF,
    parameter int WIDTH     = MQ_WIDTH_DEF,
    parameter int AE_LEVEL  = MQ_AE_LEVEL_DEF,
    parameter int OV_STAGES = MQ_OV_STAGES,
    parameter int PRS_LEAD  = MQ_PRS_LEAD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NUM_Q)-1:0] wr_addr,
    input  logic                     wr_addr_en,
    input  logic                     wr_en_n,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(NUM_Q)-1:0] rd_addr,
    input  logic                     rd_addr_en,
    input  logic                     flag_strobe,
    input  logic                     rd_en_n,
    input  logic                     out_en_n,
    input  logic                     part_rst_n,
    output logic [WIDTH-1:0]         rd_data,
    output logic                     out_valid_n,
    output logic                     almost_empty_n
);
    localparam int QW = $clog2(NUM_Q);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [QW-1:0] wq, rq;
    logic          w_vld, r_vld, w_set, r_set;
    logic          rd_load;
    logic [AW-1:0] w_slot, r_slot;
    logic          w_full, r_near;
    logic [PW-1:0] r_cnt;
    logic          prs_take, wr_fire, rd_fire, r_invalid;

    // Purpose: a read selection is blocked when it coincides with the flag strobe.
    always_comb rd_load = rd_addr_en && !flag_strobe;

    mq_sel_port #(.QW(QW), .LEAD(PRS_LEAD)) u_wsel (
        .clk(clk), .rst_n(rst_n), .load(wr_addr_en), .addr(wr_addr),
        .sel_q(wq), .sel_vld(w_vld), .settled(w_set));

    mq_sel_port #(.QW(QW), .LEAD(PRS_LEAD)) u_rsel (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .addr(rd_addr),
        .sel_q(rq), .sel_vld(r_vld), .settled(r_set));

    // Purpose: decide partial reset and the read and write events of this cycle.
    always_comb begin
        prs_take = !part_rst_n && w_set && r_set && (wq == rq);
        wr_fire  = !prs_take && w_vld && !wr_en_n && !w_full;
        rd_fire  = !prs_take && r_vld && !rd_en_n && !out_en_n && (r_cnt != '0);
    end

    mq_ptr_table #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wq(wq), .rq(rq),
        .wr_fire(wr_fire), .rd_fire(rd_fire), .clr(prs_take), .clr_q(rq),
        .w_slot(w_slot), .r_slot(r_slot), .w_full(w_full),
        .r_cnt(r_cnt), .r_near_empty(r_near));

    mq_word_store #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(wr_fire), .waddr({wq, w_slot}), .wdata(wr_data),
        .re(rd_fire), .raddr({rq, r_slot}), .rdata(rd_data));

    // Purpose: status fed to the valid pipeline.
    always_comb r_invalid = !r_vld || (r_cnt == '0);

    mq_valid_pipe #(.STAGES(OV_STAGES)) u_ov (
        .clk(clk), .rst_n(rst_n), .invalid_in(r_invalid), .valid_n(out_valid_n));

    // Purpose: almost-empty flag of the selected read queue.
    always_comb almost_empty_n = !(r_vld && r_near);

    AST_RD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_vld || r_cnt == '0 || out_en_n) |=> $stable(rd_data));   // R5
    AST_ILLEGAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_en && flag_strobe) |=> ($stable(rq) && $stable(r_vld)));   // R10
    AST_PRS_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        prs_take |-> (w_vld && r_vld && !wr_fire && !rd_fire));   // R8
endmodule

// File: tb/mq_rdport_ctrl_tb_top.sv
`timescale 1ns/1ps
module mq_rdport_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic        wr_addr_en = 1'b0;
    logic        wr_en_n = 1'b1;
    logic [17:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic        rd_addr_en = 1'b0;
    logic        flag_strobe = 1'b0;
    logic        rd_en_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic        part_rst_n = 1'b1;
    logic [17:0] rd_data;
    logic        out_valid_n;
    logic        almost_empty_n;

    always #2 clk = ~clk;   // 250 MHz

    mq_rdport_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_addr(wr_addr), .wr_addr_en(wr_addr_en), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_addr_en(rd_addr_en), .flag_strobe(flag_strobe),
        .rd_en_n(rd_en_n), .out_en_n(out_en_n), .part_rst_n(part_rst_n),
        .rd_data(rd_data), .out_valid_n(out_valid_n), .almost_empty_n(almost_empty_n));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [17:0] mq [32][$];
    logic [17:0] exp_q [$];
    logic [17:0] last_data = '0;
    logic [4:0]  m_wq = '0, m_rq = '0;
    bit          m_wsel = 0, m_rsel = 0;
    int          m_wage = 0, m_rage = 0;
    bit          m_s0 = 1, m_s1 = 1;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: scoreboard for read data
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (exp_q.size() > 0) begin
                logic [17:0] e;
                e = exp_q.pop_front();
                last_data = e;
                chk({"R4 ", cur_req}, "rd_data", int'(rd_data), int'(e));
            end else begin
                chk({"R5 ", cur_req}, "rd_data held", int'(rd_data), int'(last_data));
            end
        end
    end

    // Driver: applies one edge, predicts its effect, then checks the flags.
    task automatic tick();
        bit inv, prs, wf, rf;
        inv = !m_rsel || (mq[m_rq].size() == 0);
        prs = !part_rst_n && m_wsel && m_rsel && (m_wq == m_rq) && m_wage >= 2 && m_rage >= 2;
        wf  = !prs && m_wsel && !wr_en_n && (mq[m_wq].size() < 16);
        rf  = !prs && m_rsel && !rd_en_n && !out_en_n && (mq[m_rq].size() > 0);
        if (rf) exp_q.push_back(mq[m_rq].pop_front());
        if (wf) mq[m_wq].push_back(wr_data);
        if (prs) mq[m_rq].delete();
        if (wr_addr_en) begin m_wq = wr_addr; m_wsel = 1; m_wage = 1; end
        else if (m_wsel && m_wage < 2) m_wage++;
        if (rd_addr_en && !flag_strobe) begin m_rq = rd_addr; m_rsel = 1; m_rage = 1; end
        else if (m_rsel && m_rage < 2) m_rage++;
        @(posedge clk);
        #1;
        m_s1 = m_s0;
        m_s0 = inv;
        chk({"R6 ", cur_req}, "out_valid_n", int'(out_valid_n), int'(m_s1));
        chk({"R7 ", cur_req}, "almost_empty_n", int'(almost_empty_n),
            int'(!(m_rsel && mq[m_rq].size() <= 2)));
        @(negedge clk);
    endtask

    task automatic idle();
        wr_addr_en = 0; rd_addr_en = 0; flag_strobe = 0;
        wr_en_n = 1; rd_en_n = 1; out_en_n = 1; part_rst_n = 1;
    endtask

    task automatic sel_w(int q); idle(); wr_addr = 5'(q); wr_addr_en = 1; tick(); idle(); endtask
    task automatic sel_r(int q); idle(); rd_addr = 5'(q); rd_addr_en = 1; tick(); idle(); endtask
    task automatic put(logic [17:0] d); idle(); wr_en_n = 0; wr_data = d; tick(); idle(); endtask
    task automatic get(); idle(); rd_en_n = 0; out_en_n = 0; tick(); idle(); endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(11));
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "rd_data after reset", int'(rd_data), 0);
        chk("R1", "out_valid_n after reset", int'(out_valid_n), 1);
        chk("R1", "almost_empty_n after reset", int'(almost_empty_n), 1);
        rst_n = 1;
        mon_on = 1;
        get();   // no queue selected: ignored (R5)

        cur_req = "R2";
        sel_w(3);
        for (int i = 0; i < 5; i++) put(18'h100 + 18'(i));
        sel_r(3);
        idle(); rd_en_n = 0; out_en_n = 1; tick(); idle();   // R5: output disabled
        cur_req = "R4";
        repeat (7) get();   // drains past empty: R5, R6
        tick(); tick();

        cur_req = "R3";
        sel_w(7);
        for (int i = 0; i < 18; i++) put(18'h2A000 + 18'(i));
        sel_r(7);
        repeat (17) get();

        cur_req = "R10";
        sel_w(5);
        repeat (4) put(18'h3C3C3);
        idle(); rd_addr = 5'd5; rd_addr_en = 1; flag_strobe = 1; tick(); idle();
        tick(); tick(); get();

        cur_req = "R9";
        sel_w(6);
        repeat (3) put(18'h15555);

        cur_req = "R8";
        idle(); wr_addr = 5'd5; wr_addr_en = 1; rd_addr = 5'd5; rd_addr_en = 1; tick(); idle();
        part_rst_n = 0; tick(); idle();     // too early: ignored
        get();
        part_rst_n = 0; tick(); idle();     // accepted: queue 5 cleared
        get(); tick(); tick();
        cur_req = "R9";
        sel_r(6);
        repeat (4) get();

        cur_req = "RND";
        for (int i = 0; i < 2000; i++) begin
            wr_addr_en  = ($urandom % 8) == 0;
            wr_addr     = 5'($urandom % 4);
            rd_addr_en  = ($urandom % 8) == 0;
            rd_addr     = 5'($urandom % 4);
            flag_strobe = ($urandom % 6) == 0;
            wr_en_n     = ($urandom % 2) == 0;
            wr_data     = 18'($urandom);
            rd_en_n     = ($urandom % 2) == 0;
            out_en_n    = ($urandom % 8) == 0;
            part_rst_n  = ($urandom % 25) != 0;
            tick();
        end
        idle();
        tick(); tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule